// File: doc/BRIEF.md
# Sigma-Delta Modulator Loop with Second-Order Sinc Decimator

This block is the digital half of a first-order sigma-delta converter. An external RC integrator feeds an on-chip comparator. The comparator's decision is 1 when the integrator voltage is at or above the reference and 0 otherwise. The block brings that decision through a synchroniser and registers it once per modulator clock. It then drives the registered bit back out as the one-bit feedback DAC, so the bit is subtracted at the external summing node.

The same registered bitstream feeds a cascaded integrator-comb decimator of order `ORDER` (default 2, one above the modulator's order). The integrators run at the modulator clock and wrap modulo 2^`ACC_W`. Once every `DECIM` clocks the comb stages take the difference against their one-sample delays. The top `OUT_W` bits of the `ACC_W`-bit result are issued as a sample with a one-cycle strobe. The sample can be an offset word or a two's-complement word centred on half scale. The defaults are a 26-bit filter word, a decimation of 2048 and a 16-bit sample.

Top module: `sdm_sinc2_decim`

## Requirements
- R1: While `rst_n` is low, `fb_o`, `valid_o` and `sample_o` are all 0.
- R2: `fb_o` equals the value `comp_i` held at the rising clock edge three edges earlier: two synchroniser flops followed by the feedback register.
- R3: `valid_o` is high for exactly one clock at a time, and successive strobes are exactly `DECIM` clocks apart.
- R4: The first `ORDER` decimation ticks after reset produce no strobe. With `ORDER` = 2, the first strobe follows the rising edge numbered 3·`DECIM` after reset release.
- R5: In offset format (`OUT_FMT` = FMT_OFFSET), consider a steady periodic bitstream whose period divides `DECIM`. Its filter result is `DECIM`^2 times the fraction of 1 bits, and `sample_o` is bits [`ACC_W`-1 : `ACC_W`-`OUT_W`] of that `ACC_W`-bit value.
- R6: In signed format (`OUT_FMT` = FMT_SIGNED), `DECIM`^2/2 is subtracted modulo 2^`ACC_W` before the same top bits are taken. An all-zero stream therefore gives negative half scale and a half-density stream gives 0.
- R7: An all-ones bitstream gives exactly full scale (`DECIM`^2) in every sample after fill. This holds even though the integrators wrap modulo 2^`ACC_W`.
- R8: `sample_o` does not change in any cycle where `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_i | input | 1 | Comparator decision from the analog front end |
| fb_o | output | 1 | Registered one-bit feedback DAC drive |
| sample_o | output | OUT_W | Decimated sample, top bits of the filter word |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The decimation tick and the wraparound of the second integrator can land on the same clock. In that case the comb subtracts a delayed value taken before the wrap from a current value taken after it. To provoke this, the bench holds the comparator input at 1 over many decimation periods, using a filter word only one bit wider than the growth. The second integrator then wraps many times, at varying offsets from the tick. Every sample in that run must equal full scale exactly, in both the offset and the signed instance. A single wrong carry or a truncated subtraction would show up as a sample far from that value.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   typedef enum logic {
      FMT_OFFSET = 1'b0,
      FMT_SIGNED = 1'b1
   } sample_fmt_e;

   // bits needed to hold DECIM**ORDER without loss, plus one for the full-scale code
   function automatic int unsigned cic_growth(input int unsigned decim, input int unsigned order);
      return order * $clog2(decim) + 1;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sdm_loop_front.sv
module sdm_loop_front #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic comp_i,
   output logic bit_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sdm_loop_front: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   fb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         fb_q   <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], comp_i};
         fb_q   <= sync_q[SYNC_STAGES-1];
      end
   end

   assign bit_o = fb_q;

   // cycles since reset, used only to keep the latency check inside valid history
   logic [1:0] settle_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                settle_q <= 2'd0;
      else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
   end

   if (SYNC_STAGES == 2) begin : g_lat_chk
      AST_FB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         (settle_q == 2'd3) |-> (bit_o == $past(comp_i, 3)))  // R2
         else $error("feedback latency broken");
   end

endmodule

// File: rtl/sdm_integrator.sv
module sdm_integrator #(
   parameter int unsigned W = 26
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] acc_q;

   // modulo 2^W accumulation; the comb differences cancel the wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_q + din;
   end

   assign dout = acc_q;

endmodule

// File: rtl/sdm_comb.sv
module sdm_comb #(
   parameter int unsigned W = 26
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] dly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  dly_q <= '0;
      else if (en) dly_q <= din;
   end

   assign dout = din - dly_q;

endmodule

// File: rtl/sdm_decim_ctrl.sv
module sdm_decim_ctrl #(
   parameter int unsigned DECIM = 2048,
   parameter int unsigned ORDER = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o,
   output logic primed_o
);

   localparam int unsigned CNT_W  = (DECIM > 1) ? $clog2(DECIM) : 1;
   localparam int unsigned FILL_W = $clog2(ORDER + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [FILL_W-1:0] fill_q;

   assign tick_o   = (cnt_q == CNT_W'(DECIM - 1));
   assign primed_o = (fill_q == FILL_W'(ORDER));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // one tick per comb delay must pass before the output means anything
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   fill_q <= '0;
      else if (tick_o && !primed_o) fill_q <= fill_q + 1'b1;
   end

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt_q == '0))  // R3
      else $error("decimation counter did not restart");

   AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      primed_o |=> primed_o)  // R4
      else $error("fill state dropped");

endmodule

// File: rtl/sdm_sinc2_decim.sv
module sdm_sinc2_decim #(
   parameter int unsigned          DECIM       = 2048,
   parameter int unsigned          ORDER       = 2,
   parameter int unsigned          ACC_W       = 26,
   parameter int unsigned          OUT_W       = 16,
   parameter int unsigned          SYNC_STAGES = 2,
   parameter sdm_pkg::sample_fmt_e OUT_FMT     = sdm_pkg::FMT_OFFSET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             comp_i,
   output logic             fb_o,
   output logic [OUT_W-1:0] sample_o,
   output logic             valid_o
);

   localparam int unsigned    NEED_W     = sdm_pkg::cic_growth(DECIM, ORDER);
   localparam int unsigned    FS_LOG2    = ORDER * $clog2(DECIM);
   localparam logic [ACC_W:0] FULL_WIDE  = (ACC_W + 1)'(1) << FS_LOG2;
   localparam logic [ACC_W-1:0] FULL_SCALE = FULL_WIDE[ACC_W-1:0];
   localparam logic [ACC_W-1:0] HALF_SCALE = FULL_WIDE[ACC_W:1];

   // elaboration-time parameter checks
   if (!sdm_pkg::is_pow2(DECIM) || DECIM < 2) begin : g_bad_decim
      $error("sdm_sinc2_decim: DECIM must be a power of two, at least 2");
   end
   if (ORDER < 1) begin : g_bad_order
      $error("sdm_sinc2_decim: ORDER must be at least 1");
   end
   if (ACC_W < NEED_W) begin : g_bad_accw
      $error("sdm_sinc2_decim: ACC_W too narrow for DECIM**ORDER");
   end
   if (OUT_W > ACC_W || OUT_W < 1) begin : g_bad_outw
      $error("sdm_sinc2_decim: OUT_W must lie in 1..ACC_W");
   end

   // modulator loop: synchronise, register, feed back
   logic bitstream;

   sdm_loop_front #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_front (
      .clk    (clk),
      .rst_n  (rst_n),
      .comp_i (comp_i),
      .bit_o  (bitstream)
   );

   assign fb_o = bitstream;

   // integrator cascade at the modulator rate
   logic [ACC_W-1:0] integ [0:ORDER];
   assign integ[0] = {{(ACC_W-1){1'b0}}, bitstream};

   for (genvar gi = 0; gi < ORDER; gi++) begin : g_integ
      sdm_integrator #(
         .W (ACC_W)
      ) u_integ (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (integ[gi]),
         .dout  (integ[gi+1])
      );
   end

   // decimation timing
   logic tick;
   logic primed;

   sdm_decim_ctrl #(
      .DECIM (DECIM),
      .ORDER (ORDER)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_o   (tick),
      .primed_o (primed)
   );

   // comb cascade, delays advance once per decimation tick
   logic [ACC_W-1:0] comb [0:ORDER];
   assign comb[0] = integ[ORDER];

   for (genvar gc = 0; gc < ORDER; gc++) begin : g_comb
      sdm_comb #(
         .W (ACC_W)
      ) u_comb (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (tick),
         .din   (comb[gc]),
         .dout  (comb[gc+1])
      );
   end

   // output format
   logic [ACC_W-1:0] fmt_word;

   if (OUT_FMT == sdm_pkg::FMT_SIGNED) begin : g_fmt_signed
      assign fmt_word = comb[ORDER] - HALF_SCALE;
   end else begin : g_fmt_offset
      assign fmt_word = comb[ORDER];
   end

   logic [OUT_W-1:0] sample_q;
   logic             valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= tick && primed;
         if (tick && primed) sample_q <= fmt_word[ACC_W-1 -: OUT_W];
      end
   end

   assign sample_o = sample_q;
   assign valid_o  = valid_q;

   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o)  // R3
      else $error("strobe wider than one cycle");

   AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(sample_o))  // R8
      else $error("sample changed without strobe");

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && primed) |-> (comb[ORDER] <= FULL_SCALE))  // R7
      else $error("comb result beyond full scale");

   AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(primed))  // R4
      else $error("strobe before comb delays filled");

endmodule

// File: tb/sdm_sinc2_decim_tb.sv
`timescale 1ns/1ps
module sdm_sinc2_decim_tb;

   localparam int unsigned DECIM = 64;
   localparam int unsigned ORDER = 2;
   localparam int unsigned ACC_W = 14;
   localparam int unsigned OUT_W = 8;
   localparam int unsigned SHIFT = ACC_W - OUT_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             comp = 1'b0;
   logic             fb_u, fb_s;
   logic [OUT_W-1:0] sample_u, sample_s;
   logic             valid_u, valid_s;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sdm_sinc2_decim #(
      .DECIM (DECIM), .ORDER (ORDER), .ACC_W (ACC_W), .OUT_W (OUT_W),
      .SYNC_STAGES (2), .OUT_FMT (sdm_pkg::FMT_OFFSET)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .comp_i (comp),
      .fb_o (fb_u), .sample_o (sample_u), .valid_o (valid_u)
   );

   sdm_sinc2_decim #(
      .DECIM (DECIM), .ORDER (ORDER), .ACC_W (ACC_W), .OUT_W (OUT_W),
      .SYNC_STAGES (2), .OUT_FMT (sdm_pkg::FMT_SIGNED)
   ) u_dut_s (
      .clk (clk), .rst_n (rst_n), .comp_i (comp),
      .fb_o (fb_s), .sample_o (sample_s), .valid_o (valid_s)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // R1: outputs at zero while reset is held
   task automatic t_reset();
      rst_n = 1'b0;
      comp  = 1'b1;
      repeat (5) @(negedge clk);
      chk(fb_u == 1'b0,      "R1", "fb in reset",     fb_u, 0);
      chk(valid_u == 1'b0,   "R1", "valid in reset",  valid_u, 0);
      chk(sample_u == '0,    "R1", "sample in reset", sample_u, 0);
      chk(sample_s == '0 && valid_s == 1'b0, "R1", "signed outputs in reset",
          {valid_s, sample_s}, 0);
   endtask

   // R4: first strobe after exactly (ORDER+1)*DECIM edges
   task automatic t_fill();
      int first = -1;
      rst_n = 1'b0;
      comp  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 1; k <= (ORDER + 2) * DECIM; k++) begin
         @(negedge clk);
         if (valid_u && first < 0) first = k;
      end
      chk(first == (ORDER + 1) * DECIM, "R4", "first strobe edge", first, (ORDER + 1) * DECIM);
   endtask

   // R2: feedback follows comparator three edges later
   task automatic t_latency();
      logic [2:0] seen_hi;
      logic [2:0] seen_lo;
      @(negedge clk);
      comp = 1'b0;
      repeat (4) @(negedge clk);
      comp = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         seen_hi[k] = fb_u;
      end
      chk(seen_hi == 3'b100, "R2", "rising fb edges 1..3", seen_hi, 3'b100);
      repeat (3) @(negedge clk);
      comp = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         seen_lo[k] = fb_u;
      end
      chk(seen_lo == 3'b011, "R2", "falling fb edges 1..3", seen_lo, 3'b011);
      chk(fb_s == fb_u, "R2", "both instances fb", fb_s, fb_u);
   endtask

   // periodic stream; samples from the 4th strobe on are fully inside the pattern
   task automatic run_pattern(input logic [7:0] pat, input int per, input int n_strobes,
                              input string req_u, input string req_s);
      int      ones = 0;
      longint  fs   = longint'(DECIM) * DECIM;
      longint  raw;
      longint  exp_u, exp_s;
      int      seen = 0, idx = 0, cyc = 0, last = -1;
      int      gap_err = 0, hold_err = 0, wide_err = 0, pair_err = 0;
      bit      prev_v = 1'b0;
      logic [OUT_W-1:0] held_u = '0, held_s = '0;
      for (int b = 0; b < per; b++) ones += pat[b];
      raw   = (fs * ones) / per;
      exp_u = (raw >> SHIFT) & ((64'd1 << OUT_W) - 1);
      exp_s = (((raw - fs / 2) & ((64'd1 << ACC_W) - 1)) >> SHIFT);
      while (seen < n_strobes) begin
         @(negedge clk);
         comp = pat[idx];
         idx  = (idx + 1) % per;
         if (valid_u != valid_s) pair_err++;
         if (valid_u && prev_v) wide_err++;
         if (valid_u) begin
            seen++;
            if (last >= 0 && (cyc - last) != DECIM) gap_err++;
            last = cyc;
            if (seen >= 4) begin
               chk(sample_u == OUT_W'(exp_u), req_u, "offset sample", sample_u, exp_u);
               chk(sample_s == OUT_W'(exp_s), req_s, "signed sample", sample_s, exp_s);
            end
            held_u = sample_u;
            held_s = sample_s;
         end else if (seen > 0) begin
            if (sample_u != held_u || sample_s != held_s) hold_err++;
         end
         prev_v = valid_u;
         cyc++;
      end
      chk(gap_err == 0,  "R3", "strobe spacing errors", gap_err, 0);
      chk(wide_err == 0 && pair_err == 0, "R3", "strobe width/pair errors",
          wide_err + pair_err, 0);
      chk(hold_err == 0, "R8", "sample changes between strobes", hold_err, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      t_reset();
      t_fill();
      t_latency();
      run_pattern(8'h00, 1, 6, "R5", "R6");         // all zeros
      run_pattern(8'b00000001, 2, 6, "R5", "R6");   // half density
      run_pattern(8'b00000001, 4, 6, "R5", "R6");   // quarter density
      run_pattern(8'b00000111, 8, 6, "R5", "R6");   // three eighths
      run_pattern(8'hFF, 1, 30, "R7", "R7");        // full scale with wraps
      done = 1'b1;
      summary();
      $finish;
   end

endmodule